// File: doc/BRIEF.md
# Quad-channel converter serial load front-end

This block is the digital control section of a four-channel, 12-bit converter, rebuilt as synchronous logic driven by a fast system clock. A host writes a 16-bit word over a three-wire serial link: an active-low select, a serial clock and a data line. The select and the clock are combined by a logical OR. Every rising edge of that OR moves one data bit into a shift register. The two bits sent first pick the target channel. The two bits after them carry no meaning. The twelve bits sent last form the channel code, most significant bit first.

An active-low load input makes the addressed channel register follow the code field of the shift register for as long as it stays low. While load is high, every channel register holds its value. An asynchronous clear input forces all four channel registers to zero-scale or to mid-scale, chosen by a level input, and it leaves the shift register untouched.

All serial and load inputs pass through two-flop synchronizers. A two-state tracker, with states `PH_LOW` and `PH_HIGH`, follows the synchronized OR level:
- `PH_LOW -> PH_HIGH` is taken when the OR goes high, and it issues one shift.
- `PH_HIGH -> PH_LOW` is taken when the OR goes low.
- Each state stays where it is while the OR level does not change.

System reset enters `PH_HIGH`. The system clock must run at least four times faster than the fastest serial edge.

Top module: `qdac_frontend`

## Requirements
- R1: A 16-bit word followed by a load pulse (`load_n_in` low, then high again) writes word bits [11:0] to the channel register chosen by word bits [15:14]. Bit 15 is sent first. Word bits [13:12] have no effect.
- R2: Address bits [15:14] select channels as follows: 00 selects channel 0, 01 selects 1, 10 selects 2 and 11 selects 3. Channel i is `chan_codes[12*i+11:12*i]`. At most one channel register changes in any cycle while clear is inactive.
- R3: The shift register moves by one bit, taking in the synchronized data bit at the low end, on each rising edge of (`csel_n_in` OR `sclk_in`) and at no other time. Holding `sclk_in` low and toggling `csel_n_in` shifts in the same way as toggling the clock.
- R4: While `csel_n_in` is high, toggling `sclk_in` and `sdat_in` leaves the shift register unchanged.
- R5: If `csel_n_in` rises while `sclk_in` is low, one extra bit is shifted in. The address and the code of the stored word move by one position.
- R6: While `load_n_in` is high, no channel register changes, even while words are being shifted.
- R7: If bits are shifted while `load_n_in` is low, every channel addressed along the way is overwritten. Each such channel keeps the code field that was present when it was last addressed.
- R8: While `clr_n_in` is low, all channel registers read 0x000 if `clr_mid_in` is 0, or 0x800 if it is 1. This takes effect without waiting for a system clock edge.
- R9: Clear leaves the shift register contents unchanged. After clear is released with load high, the channel registers keep the reset code, and a later load pulse writes the word that was stored before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Active-low system reset for the synchronizers, the edge tracker and the shift register |
| csel_n_in | input | 1 | Serial select, active low |
| sclk_in | input | 1 | Serial clock |
| sdat_in | input | 1 | Serial data |
| load_n_in | input | 1 | Channel load, active low (transparent while low) |
| clr_n_in | input | 1 | Asynchronous channel clear, active low |
| clr_mid_in | input | 1 | Clear code select: 0 gives zero-scale, 1 gives mid-scale |
| chan_codes | output | 48 | Four 12-bit channel codes; channel i is at bits [12*i+11:12*i] |

## Verification
The bench drives a word with the select line as the shift clock while the serial clock is held low. A design that ANDed the two inputs, or watched only the clock, would lose that word. It lets the select rise while the clock is low and expects the stored word to move by one bit, landing on a different channel. A design that filtered this edge would keep the old channel. It shifts with load held low and compares all four channels against a model of the channels that the passing address bits select. A design that updated only on the final address would leave the earlier channels untouched. It also clears between a shift and a load, and then expects the shift register to still hold the earlier word. A design that cleared the shift register along with the channels would load zeros.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    // Phase of the combined select/clock level as seen in the system domain
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    // Clear value for a channel register: zero-scale or mid-scale
    function automatic logic [31:0] clear_code(input logic mid, input int unsigned width);
        logic [31:0] v;
        v = '0;
        if (mid) v[width-1] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/qdac_edge_fsm.sv
module qdac_edge_fsm
    import qdac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic or_level,
    output logic shift_en
);

    phase_e state_q;
    phase_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_HIGH;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_LOW:  if (or_level)  state_d = PH_HIGH;
            PH_HIGH: if (!or_level) state_d = PH_LOW;
            default: state_d = PH_HIGH;
        endcase
    end

    // Outputs: one shift per low-to-high transition
    always_comb begin
        shift_en = 1'b0;
        unique case (state_q)
            PH_LOW:  shift_en = or_level;
            PH_HIGH: shift_en = 1'b0;
            default: shift_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/qdac_shreg.sv
module qdac_shreg #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              din,
    output logic [WORD_W-1:0] word
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        word <= '0;
        else if (shift_en) word <= {word[WORD_W-2:0], din};
    end

endmodule

// File: rtl/qdac_chan_bank.sv
module qdac_chan_bank
    import qdac_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 12,
    parameter int ADDR_W = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     clr_n,
    input  logic                     clr_mid,
    input  logic                     load_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [CODE_W-1:0]        code,
    output logic [NUM_CH*CODE_W-1:0] codes
);

    logic [CODE_W-1:0] rst_code;
    logic [31:0]       rst_full;

    always_comb begin
        rst_full = clear_code(clr_mid, CODE_W);
        rst_code = rst_full[CODE_W-1:0];
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        logic hit;
        assign hit = !load_n && (addr == ADDR_W'(i));

        always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n)   codes[i*CODE_W +: CODE_W] <= rst_code;
            else if (hit) codes[i*CODE_W +: CODE_W] <= code;
        end
    end

endmodule

// File: rtl/qdac_frontend.sv
module qdac_frontend #(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 12,
    parameter int PAD_W  = 2
) (
    input  logic                     clk,
    input  logic                     sys_rst_n,
    input  logic                     csel_n_in,
    input  logic                     sclk_in,
    input  logic                     sdat_in,
    input  logic                     load_n_in,
    input  logic                     clr_n_in,
    input  logic                     clr_mid_in,
    output logic [NUM_CH*CODE_W-1:0] chan_codes
);

    localparam int ADDR_W = $clog2(NUM_CH);
    localparam int WORD_W = ADDR_W + PAD_W + CODE_W;

    // Synchronized inputs: {select, clock, load, data}
    logic [3:0] raw_in;
    logic [3:0] sync_q;
    logic       csel_sync;
    logic       sclk_sync;
    logic       ld_sync;
    logic       dat_sync;
    logic       or_level;
    logic       shift_en;
    logic [WORD_W-1:0] shift_q;

    assign raw_in = {csel_n_in, sclk_in, load_n_in, sdat_in};

    qdac_sync #(.W(4), .RST_VAL(4'b1110)) u_sync (
        .clk   (clk),
        .rst_n (sys_rst_n),
        .d     (raw_in),
        .q     (sync_q)
    );

    assign csel_sync = sync_q[3];
    assign sclk_sync = sync_q[2];
    assign ld_sync   = sync_q[1];
    assign dat_sync  = sync_q[0];
    assign or_level  = csel_sync | sclk_sync;

    qdac_edge_fsm u_edge (
        .clk      (clk),
        .rst_n    (sys_rst_n),
        .or_level (or_level),
        .shift_en (shift_en)
    );

    qdac_shreg #(.WORD_W(WORD_W)) u_shreg (
        .clk      (clk),
        .rst_n    (sys_rst_n),
        .shift_en (shift_en),
        .din      (dat_sync),
        .word     (shift_q)
    );

    qdac_chan_bank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_bank (
        .clk     (clk),
        .clr_n   (clr_n_in),
        .clr_mid (clr_mid_in),
        .load_n  (ld_sync),
        .addr    (shift_q[WORD_W-1 -: ADDR_W]),
        .code    (shift_q[CODE_W-1:0]),
        .codes   (chan_codes)
    );

endmodule

// File: rtl/qdac_frontend_chk.sv
module qdac_frontend_chk #(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 12,
    parameter int WORD_W = 16
) (
    input logic                     clk,
    input logic                     sys_rst_n,
    input logic                     clr_n,
    input logic                     clr_mid,
    input logic                     ld_q,
    input logic                     or_q,
    input logic                     shift_en,
    input logic [WORD_W-1:0]        sr,
    input logic [NUM_CH*CODE_W-1:0] codes
);

    logic [NUM_CH*CODE_W-1:0] prev_codes;
    logic [NUM_CH-1:0]        chg;
    logic [CODE_W-1:0]        exp_clr;

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) prev_codes <= '0;
        else            prev_codes <= codes;
    end

    always_comb begin
        for (int i = 0; i < NUM_CH; i++)
            chg[i] = prev_codes[i*CODE_W +: CODE_W] != codes[i*CODE_W +: CODE_W];
        exp_clr = '0;
        exp_clr[CODE_W-1] = clr_mid;
    end

    // R3
    shift_on_rise_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        shift_en == $rose(or_q));

    // R4
    hold_without_shift_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !shift_en |=> $stable(sr));

    // R2
    single_channel_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (clr_n && $past(clr_n)) |-> ($countones(chg) <= 1));

    // R6
    latched_hold_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (clr_n && $past(clr_n) && $past(ld_q)) |-> (chg == '0));

    // R8
    clear_value_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (!clr_n && $stable(clr_mid)) |-> (codes == {NUM_CH{exp_clr}}));

endmodule

bind qdac_frontend qdac_frontend_chk #(
    .NUM_CH (NUM_CH),
    .CODE_W (CODE_W),
    .WORD_W (WORD_W)
) u_chk (
    .clk       (clk),
    .sys_rst_n (sys_rst_n),
    .clr_n     (clr_n_in),
    .clr_mid   (clr_mid_in),
    .ld_q      (ld_sync),
    .or_q      (or_level),
    .shift_en  (shift_en),
    .sr        (shift_q),
    .codes     (chan_codes)
);

// File: tb/qdac_frontend_bench.sv
module qdac_frontend_bench;

    logic        clk = 1'b0;
    logic        sys_rst_n;
    logic        csel_n, sclk, sdat, load_n, clr_n, clr_mid;
    logic [47:0] codes;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [15:0] msr;
    logic [11:0] mch [4];

    always #10 clk = ~clk;

    qdac_frontend u_qdac_frontend (
        .clk        (clk),
        .sys_rst_n  (sys_rst_n),
        .csel_n_in  (csel_n),
        .sclk_in    (sclk),
        .sdat_in    (sdat),
        .load_n_in  (load_n),
        .clr_n_in   (clr_n),
        .clr_mid_in (clr_mid),
        .chan_codes (codes)
    );

    // {word, channel, code}
    localparam logic [29:0] VTAB [6] = '{
        {16'h0123, 2'd0, 12'h123},
        {16'h4FED, 2'd1, 12'hFED},
        {16'hB800, 2'd2, 12'h800},
        {16'hF001, 2'd3, 12'h001},
        {16'h2ABC, 2'd0, 12'hABC},
        {16'h5555, 2'd1, 12'h555}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_val(input string tag, input logic [11:0] got, input logic [11:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %03h expected %03h", tag, got, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < 4; i++)
            check_val($sformatf("%s ch%0d", tag, i), codes[i*12 +: 12], mch[i]);
    endtask

    // Model of one shift step, from R3 and R7
    task automatic mshift(input logic b);
        msr = {msr[14:0], b};
        if (!load_n) mch[msr[15:14]] = msr[11:0];
    endtask

    task automatic set_load(input logic v);
        load_n = v;
        if (!v) mch[msr[15:14]] = msr[11:0];
        tick(6);
    endtask

    task automatic clear_pulse(input logic mid);
        clr_mid = mid;
        tick(1);
        clr_n = 1'b0;
        for (int i = 0; i < 4; i++) mch[i] = mid ? 12'h800 : 12'h000;
        #1;
        check_all("R8 async clear");
        tick(2);
        clr_n = 1'b1;
        tick(2);
    endtask

    // Clock-driven word; extra=1 lets the select rise with the clock low (R5)
    task automatic send_word(input logic [15:0] w, input bit extra);
        csel_n = 1'b0;
        tick(4);
        for (int b = 15; b >= 0; b--) begin
            sclk = 1'b0; sdat = w[b]; tick(4);
            sclk = 1'b1; tick(4);
            mshift(w[b]);
        end
        if (extra) begin
            sclk = 1'b0; sdat = 1'b0; tick(4);
            csel_n = 1'b1; tick(4);
            mshift(1'b0);
            sclk = 1'b1; tick(4);
        end else begin
            csel_n = 1'b1; tick(4);
        end
    endtask

    // Select-driven word with the clock held low (R3)
    task automatic send_word_sel(input logic [15:0] w);
        sclk = 1'b0;
        tick(4);
        for (int b = 15; b >= 0; b--) begin
            csel_n = 1'b0; sdat = w[b]; tick(4);
            csel_n = 1'b1; tick(4);
            mshift(w[b]);
        end
        sclk = 1'b1;
        tick(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        sys_rst_n = 1'b0; clr_n = 1'b0; clr_mid = 1'b0;
        csel_n = 1'b1; sclk = 1'b1; sdat = 1'b0; load_n = 1'b1;
        msr = '0;
        for (int i = 0; i < 4; i++) mch[i] = 12'h000;
        tick(3);
        sys_rst_n = 1'b1;
        tick(3);
        check_all("R8 reset zero-scale");
        clr_n = 1'b1;
        tick(2);

        // R8: mid-scale clear
        clear_pulse(1'b1);

        // R1 R2: vector table
        for (int v = 0; v < 6; v++) begin
            send_word(VTAB[v][29:14], 1'b0);
            set_load(1'b0);
            set_load(1'b1);
            check_val($sformatf("R1 R2 vector %0d", v), codes[VTAB[v][13:12]*12 +: 12], VTAB[v][11:0]);
            check_all($sformatf("R2 vector %0d", v));
        end

        // R4: clock toggles with select high change nothing
        for (int b = 0; b < 16; b++) begin
            sclk = 1'b0; sdat = b[0]; tick(4);
            sclk = 1'b1; tick(4);
        end
        set_load(1'b0);
        set_load(1'b1);
        check_all("R4 select high");

        // R3: select used as shift clock
        send_word_sel(16'h8ABC);
        set_load(1'b0);
        set_load(1'b1);
        check_val("R3 select clock", codes[2*12 +: 12], 12'hABC);
        check_all("R3 select clock");

        // R9: clear leaves shift register intact
        send_word(16'h7123, 1'b0);
        clear_pulse(1'b1);
        tick(4);
        check_all("R9 latched after clear");
        set_load(1'b0);
        set_load(1'b1);
        check_val("R9 preserved word", codes[1*12 +: 12], 12'h123);
        check_all("R9 preserved word");

        // R5: select rises with clock low, extra shift moves 0x3155 to 0x62AA
        send_word(16'h3155, 1'b1);
        set_load(1'b0);
        set_load(1'b1);
        check_val("R5 extra shift ch1", codes[1*12 +: 12], 12'h2AA);
        check_all("R5 extra shift");

        // R7: shifting while load is low corrupts each passing channel
        set_load(1'b0);
        send_word(16'hC5A3, 1'b0);
        tick(4);
        check_all("R7 flow-through");
        check_val("R7 final target", codes[3*12 +: 12], 12'h5A3);
        set_load(1'b1);

        // R6: load high, a new word leaves all channels alone
        send_word(16'h4ABC, 1'b0);
        tick(4);
        check_all("R6 latched during shift");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule